// File: doc/BRIEF.md
# Memory Region Access Timing Decoder

This block sits in front of a system bus and classifies every read request from the processor or the DMA engine. From the address it picks one of the memory regions, works out the address the region should see, and returns the number of wait cycles the access costs. Fixed regions have built-in costs. Cartridge ROM and backup memory take their costs from a small programmable wait-state table.

Cartridge reads carry a sequential hint. The block demotes that hint to non-sequential in two cases: when the access lands on a 128 KiB boundary, and on the first non-DMA access after a DMA access. Backup memory is eight bits wide, so for wider reads the block reports how the byte must be replicated, and it signals that any pending prefetch must be stopped. Byte reads from cartridge ROM are turned into halfword fetches with a lane shift.

The request is accepted on a valid/ready handshake. The result appears one cycle later and is held until the consumer takes it.

Top module: `bus_timing_decoder`

## Requirements
- R1: The region comes from address bits [27:24] alone; bits [31:28] are ignored. Region codes: 0x0→boot ROM (0), 0x2→external RAM (1), 0x3→internal RAM (2), 0x4→I/O (3), 0x5→palette (4), 0x6→video (5), 0x7→object memory (6), 0x8..0xD→cartridge (7), 0xE..0xF→backup (8), anything else→unmapped (9).
- R2: The size code is 0 for byte, 1 for halfword and 2 for word; code 3 is treated as word. The reported address has its low bits cleared to the access size: none for byte, bit 0 for halfword, bits [1:0] for word.
- R3: Boot ROM, internal RAM, I/O, palette, video, object memory and unmapped accesses cost 1 cycle. External RAM costs 3 cycles for byte or halfword and 6 cycles for word.
- R4: The internal RAM address is reduced to its aligned low 15 bits. The external RAM address is reduced to its aligned low 18 bits. All upper bits read as zero.
- R5: A cartridge access reads the table entry at index {wide, seq, addr[26:24]}, where wide = 1 for word. After reset every entry holds its default: narrow non-sequential 5, narrow sequential 3, wide non-sequential 8, wide sequential 6.
- R6: The sequential hint of a cartridge access is cleared when bits [16:0] of the aligned address are all zero.
- R7: The sequential hint of a cartridge access is cleared when the previously accepted request had the DMA flag set and this one does not.
- R8: A cartridge byte read reports a halfword-aligned address and a shift of 8×addr[0]. Every other access reports a shift of 0.
- R9: A backup access reports the unaligned address and the narrow non-sequential entry for page index 6, whatever its sequential hint. Its replication code is 0 for byte, 1 for halfword (×0x0101) and 2 for word (×0x01010101). It raises the prefetch-stop flag; no other region does.
- R10: A configuration write stores its data at its index on the clock edge where it is presented. Requests accepted on later edges use the new value.
- R11: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. A request accepted on an edge gives `rsp_valid` high after that edge. The response stays unchanged while `rsp_ready` is low.
- R12: During and after reset, `rsp_valid` is low and the previous-access DMA memory is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_seq | input | 1 | Sequential hint |
| req_dma | input | 1 | Request issued by DMA |
| cfg_we | input | 1 | Wait table write enable |
| cfg_idx | input | 5 | Table index {wide, seq, page[2:0]} |
| cfg_wdata | input | CYC_W | Wait count to store |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_region | output | 4 | Region code |
| rsp_addr | output | 32 | Address as seen by the region |
| rsp_cycles | output | CYC_W | Access cost in cycles |
| rsp_repl | output | 2 | Backup data replication code |
| rsp_shift | output | 4 | Right shift for the cartridge byte lane |
| rsp_pf_stop | output | 1 | Stop pending prefetch |

## Verification
Region decoding is driven with addresses that carry junk in the top nibble and odd low bits, so the test can tell the region choice, the alignment and the RAM masking apart. Cartridge timing is probed in several ways: halfword and word sizes with the hint set and clear, addresses just off and exactly on a 128 KiB boundary, and a DMA, non-DMA, non-DMA sequence. These separate table selection, boundary demotion and the one-shot demotion after DMA. Table writes to one page, with a neighbouring page left untouched, show the indexing. A stalled consumer combined with an extra request shows that the response is held and no request is accepted while it waits.

// File: rtl/btd_pkg.sv
package btd_pkg;
  localparam int PAGE_W = 3;
  localparam int TIDX_W = PAGE_W + 2;
  localparam logic [PAGE_W-1:0] BKP_PAGE = 3'd6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [3:0] {
    RG_BOOT   = 4'd0,
    RG_EXTRAM = 4'd1,
    RG_INTRAM = 4'd2,
    RG_IO     = 4'd3,
    RG_PAL    = 4'd4,
    RG_VID    = 4'd5,
    RG_OBJ    = 4'd6,
    RG_CART   = 4'd7,
    RG_BACKUP = 4'd8,
    RG_UNMAP  = 4'd9
  } region_e;

  typedef enum logic [1:0] {
    RP_NONE = 2'd0,
    RP_X2   = 2'd1,
    RP_X4   = 2'd2
  } repl_e;
endpackage

// File: rtl/btd_wait_table.sv
module btd_wait_table
  import btd_pkg::*;
#(
  parameter int CYC_W   = 5,
  parameter int DEF_N16 = 5,
  parameter int DEF_S16 = 3,
  parameter int DEF_N32 = 8,
  parameter int DEF_S32 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TIDX_W-1:0] wr_idx,
  input  logic [CYC_W-1:0]  wr_data,
  input  logic [TIDX_W-1:0] rd_idx,
  output logic [CYC_W-1:0]  rd_data
);
  localparam int ENTRIES = 1 << TIDX_W;

  logic [CYC_W-1:0] ent_q [ENTRIES];
  logic [CYC_W-1:0] ent_d [ENTRIES];

  function automatic logic [CYC_W-1:0] def_val(input int i);
    int wide;
    int sq;
    wide = (i >> (PAGE_W + 1)) & 1;
    sq   = (i >> PAGE_W) & 1;
    if (wide == 1) return (sq == 1) ? CYC_W'(DEF_S32) : CYC_W'(DEF_N32);
    return (sq == 1) ? CYC_W'(DEF_S16) : CYC_W'(DEF_N16);
  endfunction

  always_comb begin
    ent_d = ent_q;
    if (wr_en) ent_d[wr_idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= def_val(i);
    end else if (wr_en) begin
      ent_q <= ent_d;
    end
  end

  assign rd_data = ent_q[rd_idx];

  // R10
  cfg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/btd_region_decode.sv
module btd_region_decode
  import btd_pkg::*;
#(
  parameter int CYC_W = 5
) (
  input  logic [31:0]       addr,
  input  logic [1:0]        size,
  input  logic              seq,
  input  logic              dma,
  input  logic              prev_dma,
  output logic [3:0]        region,
  output logic [31:0]       out_addr,
  output logic              use_tbl,
  output logic [TIDX_W-1:0] tbl_idx,
  output logic [CYC_W-1:0]  fix_cyc,
  output logic [1:0]        repl,
  output logic [3:0]        shift,
  output logic              pf_stop
);
  localparam logic [CYC_W-1:0] CYC_ONE  = CYC_W'(1);
  localparam logic [CYC_W-1:0] CYC_EXTN = CYC_W'(3);
  localparam logic [CYC_W-1:0] CYC_EXTW = CYC_W'(6);

  logic [31:0] al;
  logic        is_word;
  logic        is_byte;
  logic        seq_eff;

  always_comb begin
    is_byte = (size == SZ_BYTE);
    is_word = (size == SZ_WORD) || (size == 2'd3);
    if (is_byte)              al = addr;
    else if (size == SZ_HALF) al = {addr[31:1], 1'b0};
    else                      al = {addr[31:2], 2'b00};
  end

  always_comb begin
    region   = RG_UNMAP;
    out_addr = al;
    use_tbl  = 1'b0;
    tbl_idx  = '0;
    fix_cyc  = CYC_ONE;
    repl     = RP_NONE;
    shift    = 4'd0;
    pf_stop  = 1'b0;
    seq_eff  = 1'b0;
    unique case (addr[27:24])
      4'h0: region = RG_BOOT;
      4'h2: begin
        region   = RG_EXTRAM;
        out_addr = {14'd0, al[17:0]};
        fix_cyc  = is_word ? CYC_EXTW : CYC_EXTN;
      end
      4'h3: begin
        region   = RG_INTRAM;
        out_addr = {17'd0, al[14:0]};
      end
      4'h4: region = RG_IO;
      4'h5: region = RG_PAL;
      4'h6: region = RG_VID;
      4'h7: region = RG_OBJ;
      4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: begin
        region  = RG_CART;
        seq_eff = seq && (al[16:0] != 17'd0) && !(prev_dma && !dma);
        use_tbl = 1'b1;
        tbl_idx = {is_word, seq_eff, addr[26:24]};
        if (is_byte) begin
          out_addr = {al[31:1], 1'b0};
          shift    = {al[0], 3'b000};
        end
      end
      4'hE, 4'hF: begin
        region   = RG_BACKUP;
        out_addr = addr;
        use_tbl  = 1'b1;
        tbl_idx  = {2'b00, BKP_PAGE};
        repl     = is_byte ? RP_NONE : (size == SZ_HALF) ? RP_X2 : RP_X4;
        pf_stop  = 1'b1;
      end
      default: region = RG_UNMAP;
    endcase
  end
endmodule

// File: rtl/bus_timing_decoder.sv
module bus_timing_decoder
  import btd_pkg::*;
#(
  parameter int CYC_W   = 5,
  parameter int DEF_N16 = 5,
  parameter int DEF_S16 = 3,
  parameter int DEF_N32 = 8,
  parameter int DEF_S32 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_seq,
  input  logic              req_dma,
  input  logic              cfg_we,
  input  logic [TIDX_W-1:0] cfg_idx,
  input  logic [CYC_W-1:0]  cfg_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [3:0]        rsp_region,
  output logic [31:0]       rsp_addr,
  output logic [CYC_W-1:0]  rsp_cycles,
  output logic [1:0]        rsp_repl,
  output logic [3:0]        rsp_shift,
  output logic              rsp_pf_stop
);
  logic              accept;
  logic              prev_dma_q;
  logic              valid_d;
  logic [3:0]        dec_region;
  logic [31:0]       dec_addr;
  logic              dec_use_tbl;
  logic [TIDX_W-1:0] dec_idx;
  logic [CYC_W-1:0]  dec_fix;
  logic [CYC_W-1:0]  tbl_val;
  logic [CYC_W-1:0]  cyc_d;
  logic [1:0]        dec_repl;
  logic [3:0]        dec_shift;
  logic              dec_pf;

  btd_region_decode #(.CYC_W(CYC_W)) u_dec (
    .addr     (req_addr),
    .size     (req_size),
    .seq      (req_seq),
    .dma      (req_dma),
    .prev_dma (prev_dma_q),
    .region   (dec_region),
    .out_addr (dec_addr),
    .use_tbl  (dec_use_tbl),
    .tbl_idx  (dec_idx),
    .fix_cyc  (dec_fix),
    .repl     (dec_repl),
    .shift    (dec_shift),
    .pf_stop  (dec_pf)
  );

  btd_wait_table #(
    .CYC_W(CYC_W), .DEF_N16(DEF_N16), .DEF_S16(DEF_S16),
    .DEF_N32(DEF_N32), .DEF_S32(DEF_S32)
  ) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata),
    .rd_idx  (dec_idx),
    .rd_data (tbl_val)
  );

  always_comb begin
    req_ready = !rsp_valid || rsp_ready;
    accept    = req_valid && req_ready;
    cyc_d     = dec_use_tbl ? tbl_val : dec_fix;
    if (accept)         valid_d = 1'b1;
    else if (rsp_ready) valid_d = 1'b0;
    else                valid_d = rsp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      prev_dma_q <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      if (accept) prev_dma_q <= req_dma;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_region  <= '0;
      rsp_addr    <= '0;
      rsp_cycles  <= '0;
      rsp_repl    <= '0;
      rsp_shift   <= '0;
      rsp_pf_stop <= 1'b0;
    end else if (accept) begin
      rsp_region  <= dec_region;
      rsp_addr    <= dec_addr;
      rsp_cycles  <= cyc_d;
      rsp_repl    <= dec_repl;
      rsp_shift   <= dec_shift;
      rsp_pf_stop <= dec_pf;
    end
  end

  // R11
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R11
  rsp_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
                                   $stable(rsp_cycles) && $stable(rsp_region)));

  // R3
  extram_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_region == RG_EXTRAM) |-> (rsp_cycles == CYC_W'(3) || rsp_cycles == CYC_W'(6)));

  // R4
  intram_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_region == RG_INTRAM) |-> (rsp_addr[31:15] == 17'd0));

  // R9
  backup_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_pf_stop == (rsp_region == RG_BACKUP)));
endmodule

// File: tb/tb_bus_timing_decoder.sv
`timescale 1ns/1ps
module tb_bus_timing_decoder;
  localparam int CYC_W = 5;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        req_seq;
  logic        req_dma;
  logic        cfg_we;
  logic [4:0]  cfg_idx;
  logic [CYC_W-1:0] cfg_wdata;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [3:0]  rsp_region;
  logic [31:0] rsp_addr;
  logic [CYC_W-1:0] rsp_cycles;
  logic [1:0]  rsp_repl;
  logic [3:0]  rsp_shift;
  logic        rsp_pf_stop;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bus_timing_decoder #(.CYC_W(CYC_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_seq(req_seq), .req_dma(req_dma),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_region(rsp_region),
    .rsp_addr(rsp_addr), .rsp_cycles(rsp_cycles), .rsp_repl(rsp_repl),
    .rsp_shift(rsp_shift), .rsp_pf_stop(rsp_pf_stop)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // drive at falling edge, accept at rising edge, sample at next falling edge
  task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic sq, input logic dm);
    req_addr  = a;
    req_size  = sz;
    req_seq   = sq;
    req_dma   = dm;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string rq, input logic [3:0] rg, input logic [31:0] a, input int cyc);
    chk(rq, "valid", 32'(rsp_valid), 32'd1);
    chk(rq, "region", 32'(rsp_region), 32'(rg));
    chk(rq, "addr", rsp_addr, a);
    chk(rq, "cycles", 32'(rsp_cycles), 32'(cyc));
  endtask

  task automatic t_reset();
    // R12
    chk("R12", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R11", "req_ready in reset", 32'(req_ready), 32'd1);
  endtask

  task automatic t_fixed_regions();
    issue(32'hF000_0123, 2'd1, 1'b0, 1'b0);
    expect_rsp("R1 R2 R3", 4'd0, 32'hF000_0122, 1);
    issue(32'h0204_5677, 2'd2, 1'b0, 1'b0);
    expect_rsp("R3 R4", 4'd1, 32'h0000_5674, 6);
    issue(32'h0204_5677, 2'd0, 1'b0, 1'b0);
    expect_rsp("R3 R4", 4'd1, 32'h0000_5677, 3);
    issue(32'h0300_9ABD, 2'd1, 1'b0, 1'b0);
    expect_rsp("R4", 4'd2, 32'h0000_1ABC, 1);
    issue(32'h0400_0207, 2'd3, 1'b0, 1'b0);
    expect_rsp("R2", 4'd3, 32'h0400_0204, 1);
    issue(32'h0500_0011, 2'd0, 1'b0, 1'b0);
    expect_rsp("R1", 4'd4, 32'h0500_0011, 1);
    issue(32'h0600_0012, 2'd2, 1'b0, 1'b0);
    expect_rsp("R1", 4'd5, 32'h0600_0010, 1);
    issue(32'h0700_0003, 2'd1, 1'b0, 1'b0);
    expect_rsp("R1", 4'd6, 32'h0700_0002, 1);
    issue(32'h1100_0001, 2'd1, 1'b0, 1'b0);
    expect_rsp("R1 R3", 4'd9, 32'h1100_0000, 1);
    chk("R9", "pf_stop off", 32'(rsp_pf_stop), 32'd0);
  endtask

  task automatic t_cart_table();
    issue(32'h0800_0102, 2'd1, 1'b1, 1'b0);
    expect_rsp("R5", 4'd7, 32'h0800_0102, 3);
    issue(32'h0800_0102, 2'd1, 1'b0, 1'b0);
    expect_rsp("R5", 4'd7, 32'h0800_0102, 5);
    issue(32'h0C00_0104, 2'd2, 1'b1, 1'b0);
    expect_rsp("R5", 4'd7, 32'h0C00_0104, 6);
    issue(32'h0D00_0106, 2'd2, 1'b0, 1'b0);
    expect_rsp("R5", 4'd7, 32'h0D00_0104, 8);
  endtask

  task automatic t_boundary();
    issue(32'h0802_0000, 2'd1, 1'b1, 1'b0);
    chk("R6", "cycles at boundary", 32'(rsp_cycles), 32'd5);
    issue(32'h0802_0002, 2'd1, 1'b1, 1'b0);
    chk("R6", "cycles past boundary", 32'(rsp_cycles), 32'd3);
    issue(32'h0803_0003, 2'd2, 1'b1, 1'b0);
    chk("R6", "word near 64K, not boundary", 32'(rsp_cycles), 32'd6);
    issue(32'h0804_0003, 2'd2, 1'b1, 1'b0);
    chk("R6", "aligned word on boundary", 32'(rsp_cycles), 32'd8);
  endtask

  task automatic t_dma();
    issue(32'h0800_0010, 2'd1, 1'b1, 1'b1);
    chk("R7", "DMA seq", 32'(rsp_cycles), 32'd3);
    issue(32'h0800_0012, 2'd1, 1'b1, 1'b0);
    chk("R7", "first CPU after DMA", 32'(rsp_cycles), 32'd5);
    issue(32'h0800_0014, 2'd1, 1'b1, 1'b0);
    chk("R7", "second CPU after DMA", 32'(rsp_cycles), 32'd3);
    issue(32'h0300_0000, 2'd2, 1'b0, 1'b1);
    issue(32'h0800_0016, 2'd1, 1'b1, 1'b0);
    chk("R7", "CPU after DMA to other region", 32'(rsp_cycles), 32'd5);
  endtask

  task automatic t_byte();
    issue(32'h0800_0105, 2'd0, 1'b0, 1'b0);
    expect_rsp("R8", 4'd7, 32'h0800_0104, 5);
    chk("R8", "odd shift", 32'(rsp_shift), 32'd8);
    issue(32'h0800_0104, 2'd0, 1'b0, 1'b0);
    chk("R8", "even shift", 32'(rsp_shift), 32'd0);
    issue(32'h0200_0001, 2'd0, 1'b0, 1'b0);
    chk("R8", "non-cart byte shift", 32'(rsp_shift), 32'd0);
  endtask

  task automatic t_backup();
    issue(32'h0E00_0003, 2'd2, 1'b1, 1'b0);
    expect_rsp("R9", 4'd8, 32'h0E00_0003, 5);
    chk("R9", "repl word", 32'(rsp_repl), 32'd2);
    chk("R9", "pf_stop", 32'(rsp_pf_stop), 32'd1);
    issue(32'h0F00_1235, 2'd1, 1'b0, 1'b0);
    expect_rsp("R9", 4'd8, 32'h0F00_1235, 5);
    chk("R9", "repl half", 32'(rsp_repl), 32'd1);
    issue(32'h0E00_0001, 2'd0, 1'b0, 1'b0);
    chk("R9", "repl byte", 32'(rsp_repl), 32'd0);
  endtask

  task automatic cfg_write(input logic [4:0] idx, input logic [CYC_W-1:0] val);
    cfg_idx   = idx;
    cfg_wdata = val;
    cfg_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_config();
    cfg_write(5'b0_1_001, 5'd7);
    issue(32'h0900_0010, 2'd1, 1'b1, 1'b0);
    chk("R10", "page 9 seq narrow", 32'(rsp_cycles), 32'd7);
    issue(32'h0800_0010, 2'd1, 1'b1, 1'b0);
    chk("R10", "page 8 untouched", 32'(rsp_cycles), 32'd3);
    issue(32'h0900_0010, 2'd2, 1'b1, 1'b0);
    chk("R10", "page 9 wide untouched", 32'(rsp_cycles), 32'd6);
    cfg_write(5'b0_0_110, 5'd9);
    issue(32'h0E00_0040, 2'd0, 1'b1, 1'b0);
    chk("R9 R10", "backup cost", 32'(rsp_cycles), 32'd9);
  endtask

  task automatic t_handshake();
    issue(32'h0500_0100, 2'd1, 1'b0, 1'b0);
    rsp_ready = 1'b0;
    #1;
    chk("R11", "ready low while stalled", 32'(req_ready), 32'd0);
    req_addr  = 32'h0300_0008;
    req_size  = 2'd2;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11", "valid held", 32'(rsp_valid), 32'd1);
    chk("R11", "addr held", rsp_addr, 32'h0500_0100);
    chk("R11", "region held", 32'(rsp_region), 32'd4);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    #1;
    chk("R11", "ready back", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "drained", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_size = '0; req_seq = 1'b0; req_dma = 1'b0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fixed_regions();
    t_cart_table();
    t_boundary();
    t_dma();
    t_byte();
    t_backup();
    t_config();
    t_handshake();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule